// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the control state for one eight-pin general-purpose I/O port and exposes it on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software chooses a 2-bit mode for each pin and writes the output data. It can also change individual output bits atomically through write-only set and clear addresses, so no read-modify-write is needed. Reads of the input address return the live pin levels.

A mask register freezes selected output bits. While a pin's mask bit is one, none of the three write paths can change its output bit: the direct data write, the atomic set and the atomic clear. The pin mode decides how the output bit reaches the pad. Three per-pin signals go toward the pad logic: an output value, an output enable and an open-drain flag. Pad electrical options and interrupt detection live in other blocks.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every mode field reads 3, the mask reads 0 and the output data reads 0, and all pad output enables are low.
- R2: Offset 0x00 holds the mode fields, pin p at bits [2p+1:2p]. The fields are read/write and bits 31:16 read 0. Encodings: 0 analog input, 1 push-pull output, 2 open-drain output, 3 high-impedance input.
- R3: Offset 0x08 holds the output data in bits 7:0. It is read/write and bits 31:8 read 0.
- R4: A write to offset 0x30 sets each output bit whose write data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x34 clears each output bit whose write data bit is 1 and leaves the other bits unchanged.
- R6: Offset 0x04 is the read/write output mask in bits 7:0. An output bit whose mask bit is 1 keeps its value through writes to 0x08, 0x30 and 0x34.
- R7: Offset 0x0C reads the pin input levels in bits 7:0. Writes to it change nothing.
- R8: Offsets 0x30 and 0x34 read as 0.
- R9: Any other offset reads 0, and writing to it changes no register.
- R10: A push-pull pin has its output enable high, its pad value equal to its output bit, and its open-drain flag low.
- R11: An open-drain pin has its pad value low, its open-drain flag high, and its output enable equal to the inverse of its output bit.
- R12: A pin in mode 0 or 3 has its output enable, pad value and open-drain flag all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register accessed |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_in_i | input | 8 | Pin input levels |
| pad_out_o | output | 8 | Value driven to each pad |
| pad_oe_o | output | 8 | Output enable for each pad |
| pad_od_o | output | 8 | Open-drain flag for each pad |

## Verification
The output register is driven through sequences of direct writes, sets and clears. Each sequence uses bit patterns with both ones and zeros, so a set that disturbs its zero bits or a clear that touches the wrong polarity gives a distinct value. The mask is then set on a mixed pattern (0x3C) before each of the three write paths is used. This shows whether the freeze covers every path or only some of them. A mode word mixing all four encodings is checked with two complementary output patterns, which separates push-pull data following from the inverted open-drain enable. Wide writes to narrow registers, writes to the input, set, clear and unmapped addresses, and reads of those addresses confirm that high bits and dead addresses stay at zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_ANALOG   = 2'd0,
    MODE_PUSHPULL = 2'd1,
    MODE_OPENDRN  = 2'd2,
    MODE_HIZ      = 2'd3
  } pin_mode_e;

  typedef enum logic [2:0] {
    REG_NONE, REG_MODE, REG_MASK, REG_OUT, REG_IN, REG_SET, REG_CLR
  } reg_id_e;

  localparam int unsigned OFF_MODE = 'h00;
  localparam int unsigned OFF_MASK = 'h04;
  localparam int unsigned OFF_OUT  = 'h08;
  localparam int unsigned OFF_IN   = 'h0C;
  localparam int unsigned OFF_SET  = 'h30;
  localparam int unsigned OFF_CLR  = 'h34;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_id_e           reg_id_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_MODE): reg_id_o = REG_MODE;
      ADDR_W'(OFF_MASK): reg_id_o = REG_MASK;
      ADDR_W'(OFF_OUT):  reg_id_o = REG_OUT;
      ADDR_W'(OFF_IN):   reg_id_o = REG_IN;
      ADDR_W'(OFF_SET):  reg_id_o = REG_SET;
      ADDR_W'(OFF_CLR):  reg_id_o = REG_CLR;
      default:           reg_id_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8,
  localparam int MODE_W = 2 * N_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_id_e           reg_id_i,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [N_PINS-1:0] mask_o,
  output logic [N_PINS-1:0] out_o
);
  logic [N_PINS-1:0] wbits;
  logic [N_PINS-1:0] out_req;

  assign wbits = wdata_i[N_PINS-1:0];

  always_comb begin
    out_req = out_o;
    if (we_i) begin
      unique case (reg_id_i)
        REG_OUT: out_req = wbits;
        REG_SET: out_req = out_o | wbits;
        REG_CLR: out_req = out_o & ~wbits;
        default: out_req = out_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= {N_PINS{MODE_HIZ}};
      mask_o <= '0;
      out_o  <= '0;
    end else begin
      if (we_i && reg_id_i == REG_MODE) mode_o <= wdata_i;
      if (we_i && reg_id_i == REG_MASK) mask_o <= wbits;
      // masked pins hold regardless of write path
      out_o <= (out_o & mask_o) | (out_req & ~mask_o);
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8,
  localparam int MODE_W = 2 * N_PINS
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [N_PINS-1:0] out_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_od_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    pin_mode_e pm;
    assign pm = pin_mode_e'(mode_i[2*p +: 2]);
    always_comb begin
      pad_out_o[p] = 1'b0;
      pad_oe_o[p]  = 1'b0;
      pad_od_o[p]  = 1'b0;
      unique case (pm)
        MODE_PUSHPULL: begin
          pad_out_o[p] = out_i[p];
          pad_oe_o[p]  = 1'b1;
        end
        MODE_OPENDRN: begin
          pad_oe_o[p] = ~out_i[p];  // 0 pulls low, 1 releases
          pad_od_o[p] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int MODE_W = 2 * N_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_od_o
);
  reg_id_e           reg_id;
  logic [MODE_W-1:0] mode_q;
  logic [N_PINS-1:0] mask_q;
  logic [N_PINS-1:0] out_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:MODE_W];

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .reg_id_o(reg_id)
  );

  gpio_out_ctrl #(.N_PINS(N_PINS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reg_id_i(reg_id),
    .we_i    (we_i),
    .wdata_i (wdata_i[MODE_W-1:0]),
    .mode_o  (mode_q),
    .mask_o  (mask_q),
    .out_o   (out_q)
  );

  gpio_pad_drive #(.N_PINS(N_PINS)) u_pad (
    .mode_i   (mode_q),
    .out_i    (out_q),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .pad_od_o (pad_od_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (reg_id)
      REG_MODE: rdata_o[MODE_W-1:0] = mode_q;
      REG_MASK: rdata_o[N_PINS-1:0] = mask_q;
      REG_OUT:  rdata_o[N_PINS-1:0] = out_q;
      REG_IN:   rdata_o[N_PINS-1:0] = pin_in_i;
      default:  rdata_o = '0;  // set/clear and unmapped
    endcase
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [N_PINS-1:0] wbits_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_PINS-1:0] pin_in_i,
  input logic [N_PINS-1:0] out_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic [N_PINS-1:0] pad_od_o
);
  import gpio_pkg::*;

  assert_set_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_SET)) |=>
      ((out_q & ($past(wbits_i) & ~$past(mask_q))) == ($past(wbits_i) & ~$past(mask_q))));

  assert_clr_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_CLR)) |=>
      ((out_q & $past(wbits_i) & ~$past(mask_q)) == '0));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

  assert_in_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_IN)) |-> (rdata_o == DATA_W'(pin_in_i)));

  assert_setclr_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_SET) || addr_i == ADDR_W'(OFF_CLR)) |-> (rdata_o == '0));

  assert_od_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_od_o & (pad_oe_o ^ ~out_q)) == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wbits_i (wdata_i[N_PINS-1:0]),
  .rdata_o (rdata_o),
  .pin_in_i(pin_in_i),
  .out_q   (out_q),
  .mask_q  (mask_q),
  .pad_oe_o(pad_oe_o),
  .pad_od_o(pad_od_o)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_od;
  int tests = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pin_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_od_o(pad_od)
  );

  // {wr_addr, wr_data, rd_addr, expected, req}
  localparam logic [87:0] VEC [0:9] = '{
    {8'h08, 32'h0000_00A5, 8'h08, 32'h0000_00A5, 8'd3},  // R3
    {8'h30, 32'h0000_000A, 8'h08, 32'h0000_00AF, 8'd4},  // R4
    {8'h34, 32'h0000_0081, 8'h08, 32'h0000_002E, 8'd5},  // R5
    {8'h30, 32'h0000_0000, 8'h08, 32'h0000_002E, 8'd4},  // R4 zeros
    {8'h34, 32'h0000_0000, 8'h08, 32'h0000_002E, 8'd5},  // R5 zeros
    {8'h00, 32'hFFFF_1234, 8'h00, 32'h0000_1234, 8'd2},  // R2
    {8'h08, 32'hFFFF_FF00, 8'h08, 32'h0000_0000, 8'd3},  // R3 high bits
    {8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 8'd9},  // R9
    {8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000, 8'd8},  // R8
    {8'h34, 32'h0000_000F, 8'h34, 32'h0000_0000, 8'd8}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, 32'h0000_FFFF, "R1 mode");
    rd(8'h04, 32'h0, "R1 mask");
    rd(8'h08, 32'h0, "R1 out");
    chk("R1 oe", {24'h0, pad_oe}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][87:80], VEC[i][79:48]);
      rd(VEC[i][47:40], VEC[i][39:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
    end
    rd(8'h08, 32'h0000_00F0, "R8 out after set/clr");
    rd(8'h00, 32'h0000_1234, "R9 mode untouched");
    rd(8'h04, 32'h0, "R9 mask untouched");

    // R7 input read, write ignored
    pin_in = 8'h5A;
    rd(8'h0C, 32'h0000_005A, "R7 in");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0000_005A, "R7 in after write");
    rd(8'h08, 32'h0000_00F0, "R7 out untouched");

    // R6 mask across all write paths
    wr(8'h08, 32'h0F);
    wr(8'h04, 32'h3C);
    rd(8'h04, 32'h0000_003C, "R6 mask read");
    wr(8'h08, 32'hF0);
    rd(8'h08, 32'h0000_00CC, "R6 direct");
    wr(8'h30, 32'hFF);
    rd(8'h08, 32'h0000_00CF, "R6 set");
    wr(8'h34, 32'hFF);
    rd(8'h08, 32'h0000_000C, "R6 clear");
    wr(8'h04, 32'h00);

    // pads: pins 0,1,5 push-pull; 2,3,4 open-drain; 6 analog; 7 hiz
    wr(8'h00, 32'h0000_C6A5);
    wr(8'h08, 32'h0F);
    #1;
    chk("R10 pp oe", {24'h0, pad_oe & 8'h23}, 32'h23);
    chk("R10 pp out", {24'h0, pad_out & 8'h23}, 32'h03);
    chk("R10 pp od", {24'h0, pad_od & 8'h23}, 32'h00);
    chk("R11 od oe", {24'h0, pad_oe & 8'h1C}, 32'h10);
    chk("R11 od out", {24'h0, pad_out & 8'h1C}, 32'h00);
    chk("R11 od flag", {24'h0, pad_od & 8'h1C}, 32'h1C);
    chk("R12 in pins", {24'h0, (pad_oe | pad_out | pad_od) & 8'hC0}, 32'h00);
    wr(8'h08, 32'hF0);
    #1;
    chk("R10 pp out flip", {24'h0, pad_out}, 32'h20);
    chk("R11 od oe flip", {24'h0, pad_oe}, 32'h2F);
    chk("R12 in pins flip", {24'h0, (pad_oe | pad_out | pad_od) & 8'hC0}, 32'h00);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    rd(8'h00, 32'h0000_FFFF, "R1 mode after reset");
    rd(8'h08, 32'h0, "R1 out after reset");
    chk("R1 oe after reset", {24'h0, pad_oe}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", tests, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", tests, bad);
      $finish;
    end
  end
endmodule